// File: doc/BRIEF.md
# Submission Queue Command Fetcher

This block serves one submission ring kept in host memory. The ring has a configurable number of equal 64-byte slots. Host software announces new work by writing a tail index into a doorbell port, and that write is the only thing that starts a fetch. While the internal head index trails the tail, the block issues a memory read for the slot at the head. It gathers the returned data beats into one 512-bit command word. It then offers that word downstream, tagged with the queue identifier and the slot number, so that a consumer which finishes commands out of order can still name each one.

The head moves forward only when the consumer accepts a command, and it wraps to zero after the last slot. It is exported so that a completion path can report how much of the ring has been consumed. A doorbell carrying an index outside the ring is dropped and flagged. Only one command is in flight at a time.

Handshake rules for both stream interfaces: a transfer happens on a clock edge where valid and ready are both high. Once valid is raised, it and its payload hold until that transfer. Ready may be dropped at any time to apply back-pressure.

Top module: `sq_fetch_engine`

## Requirements
- R1: While reset is applied and right after it, `sq_head` is 0, `rd_req_valid`, `rd_rsp_ready` and `cmd_valid` are low, and `db_err` is low.
- R2: A doorbell write with `db_tail` < `cfg_depth` replaces the stored tail. A read request is raised only while the head differs from the stored tail, and none is raised when they are equal.
- R3: A doorbell write with `db_tail` >= `cfg_depth` leaves the stored tail and the head unchanged and starts no fetch. `db_err` is high for exactly the one cycle after such a write and low otherwise.
- R4: Each read request carries address `cfg_base + head*64`. At most one command is in flight. Request valid and address hold until `rd_req_ready` is seen.
- R5: A command arrives as eight 64-bit response beats. Beat k, counted from 0, lands in bits [64k+63:64k] of `cmd_data`. `rd_rsp_ready` is high only while beats of an issued request are awaited.
- R6: `cmd_slot` equals the slot the command was read from and `cmd_qid` equals `cfg_qid`. Under back-pressure `cmd_valid`, `cmd_data` and `cmd_slot` stay stable.
- R7: The head advances by one only on a command handshake. From `cfg_depth`-1 it wraps to 0.
- R8: `sq_head` shows the current head index on every cycle.
- R9: A valid doorbell write that falls in the same cycle as a command handshake takes effect together with the head advance, and fetching continues up to the new tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | ADDR_W | Byte address of slot 0 |
| cfg_depth | input | IDX_W | Number of slots (2 to 2^IDX_W-1) |
| cfg_qid | input | QID_W | Queue identifier attached to commands |
| db_wr | input | 1 | Doorbell write strobe |
| db_tail | input | IDX_W | Tail index written by the host |
| db_err | output | 1 | One-cycle flag for a rejected doorbell |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | ADDR_W | Byte address of the slot to read |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_ready | output | 1 | Engine accepts a beat |
| rd_rsp_data | input | DATA_W | Response beat data |
| cmd_valid | output | 1 | Assembled command valid |
| cmd_ready | input | 1 | Consumer accepts command |
| cmd_data | output | 512 | Assembled command word |
| cmd_qid | output | QID_W | Queue identifier of the command |
| cmd_slot | output | IDX_W | Slot index of the command |
| sq_head | output | IDX_W | Current head index |

## Verification
Two events can fall in the same cycle: the tail being rewritten by a doorbell, and the head being advanced by a command handshake. The bench arms a one-shot trigger. At the first cycle where `cmd_valid` is high, the trigger drives a doorbell that wraps the tail and raises `cmd_ready` in that same cycle. The reference model applies both updates together. The bench then requires that the head ends at the new tail and that the number of commands delivered matches the slots between the old head and the new tail.

// File: rtl/sq_fetch_pkg.sv
package sq_fetch_pkg;
  localparam int unsigned SLOT_BYTES = 64;
  localparam int unsigned SLOT_SHIFT = $clog2(SLOT_BYTES);
  localparam int unsigned CMD_BITS   = SLOT_BYTES * 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BEATS = 2'd2,
    ST_OUT   = 2'd3
  } fetch_st_e;
endpackage

// File: rtl/sq_tail_reg.sv
module sq_tail_reg #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_depth,
  input  logic             db_wr,
  input  logic [IDX_W-1:0] db_tail,
  output logic [IDX_W-1:0] tail,
  output logic             db_err
);
  logic in_range;
  assign in_range = (db_tail < cfg_depth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail   <= '0;
      db_err <= 1'b0;
    end else begin
      db_err <= db_wr && !in_range;
      if (db_wr && in_range) tail <= db_tail;
    end
  end

  // R3: an out-of-range doorbell leaves the tail alone and raises the flag
  a_r3_bad_db_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr && (db_tail >= cfg_depth)) |=> ($stable(tail) && db_err));

  // R2: a legal doorbell is taken
  a_r2_db_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr && (db_tail < cfg_depth)) |=> (tail == $past(db_tail)));
endmodule

// File: rtl/sq_head_ctr.sv
module sq_head_ctr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_depth,
  input  logic             advance,
  output logic [IDX_W-1:0] head
);
  logic             at_last;
  logic [IDX_W-1:0] head_nxt;

  assign at_last  = (head == cfg_depth - IDX_W'(1));
  assign head_nxt = at_last ? '0 : head + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       head <= '0;
    else if (advance) head <= head_nxt;
  end

  // R7: wrap from the last slot back to slot 0
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (head == cfg_depth - IDX_W'(1))) |=> (head == '0));

  // R7: head stays inside the ring
  a_r7_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    head < cfg_depth);
endmodule

// File: rtl/sq_beat_asm.sv
module sq_beat_asm #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned CMD_BITS = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                beat_valid,
  input  logic [DATA_W-1:0]   beat_data,
  output logic [CMD_BITS-1:0] word,
  output logic                last_beat
);
  localparam int unsigned BEATS = CMD_BITS / DATA_W;
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CNT_W-1:0] cnt;

  assign last_beat = beat_valid && (cnt == CNT_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (last_beat)  cnt <= '0;
    else if (beat_valid) cnt <= cnt + CNT_W'(1);
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                lane_q <= '0;
      else if (beat_valid && cnt == CNT_W'(g))   lane_q <= beat_data;
    end
    assign word[g*DATA_W +: DATA_W] = lane_q;
  end

  // R5: after the final beat the counter is ready for the next command
  a_r5_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (cnt == '0));
endmodule

// File: rtl/sq_fetch_engine.sv
module sq_fetch_engine
  import sq_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned QID_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [IDX_W-1:0]    cfg_depth,
  input  logic [QID_W-1:0]    cfg_qid,
  input  logic                db_wr,
  input  logic [IDX_W-1:0]    db_tail,
  output logic                db_err,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [ADDR_W-1:0]   rd_req_addr,
  input  logic                rd_rsp_valid,
  output logic                rd_rsp_ready,
  input  logic [DATA_W-1:0]   rd_rsp_data,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [CMD_BITS-1:0] cmd_data,
  output logic [QID_W-1:0]    cmd_qid,
  output logic [IDX_W-1:0]    cmd_slot,
  output logic [IDX_W-1:0]    sq_head
);
  fetch_st_e        st, st_nxt;
  logic [IDX_W-1:0] tail, head;
  logic             beat_take, last_beat, cmd_take;

  sq_tail_reg #(.IDX_W(IDX_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
    .db_wr(db_wr), .db_tail(db_tail), .tail(tail), .db_err(db_err)
  );

  sq_head_ctr #(.IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
    .advance(cmd_take), .head(head)
  );

  sq_beat_asm #(.DATA_W(DATA_W), .CMD_BITS(CMD_BITS)) u_asm (
    .clk(clk), .rst_n(rst_n), .clear(st == ST_REQ),
    .beat_valid(beat_take), .beat_data(rd_rsp_data),
    .word(cmd_data), .last_beat(last_beat)
  );

  assign rd_req_valid = (st == ST_REQ);
  assign rd_rsp_ready = (st == ST_BEATS);
  assign cmd_valid    = (st == ST_OUT);
  assign beat_take    = rd_rsp_valid && rd_rsp_ready;
  assign cmd_take     = cmd_valid && cmd_ready;
  assign rd_req_addr  = cfg_base + (ADDR_W'(head) << SLOT_SHIFT);
  assign cmd_slot     = head;
  assign cmd_qid      = cfg_qid;
  assign sq_head      = head;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (head != tail) st_nxt = ST_REQ;
      ST_REQ:   if (rd_req_ready) st_nxt = ST_BEATS;
      ST_BEATS: if (last_beat)    st_nxt = ST_OUT;
      ST_OUT:   if (cmd_ready)    st_nxt = ST_IDLE;
      default:                    st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  // R4: a pending request holds its address
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R6: an offered command holds under back-pressure
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data) && $stable(cmd_slot)));

  // R7: head moves only on a command handshake
  a_r7_head_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(sq_head));

  // R4: one command in flight, phases never overlap
  a_r4_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_req_valid, rd_rsp_ready, cmd_valid}) <= 1);

  // R2: a request starts only when work was pending
  a_r2_start_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(head != tail));
endmodule

// File: tb/sq_fetch_engine_tb.sv
module sq_fetch_engine_tb;
  localparam int IDX_W = 8;
  localparam int QID_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [63:0]       cfg_base = 64'h0000_0001_0000_0000;
  logic [IDX_W-1:0]  cfg_depth = 8'd8;
  logic [QID_W-1:0]  cfg_qid = 16'd5;
  logic              db_wr = 1'b0;
  logic [IDX_W-1:0]  db_tail = '0;
  logic              db_err;
  logic              rd_req_valid, rd_req_ready = 1'b0;
  logic [63:0]       rd_req_addr;
  logic              rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [63:0]       rd_rsp_data = '0;
  logic              cmd_valid, cmd_ready = 1'b0;
  logic [511:0]      cmd_data;
  logic [QID_W-1:0]  cmd_qid;
  logic [IDX_W-1:0]  cmd_slot, sq_head;

  sq_fetch_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
    .cfg_qid(cfg_qid), .db_wr(db_wr), .db_tail(db_tail), .db_err(db_err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_qid(cmd_qid), .cmd_slot(cmd_slot), .sq_head(sq_head)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int m_head = 0, m_tail = 0, cmd_count = 0;
  bit m_err = 1'b0;
  longint unsigned pend[$];
  int  beat_idx = 0;
  int  rdy_pct = 100, rsp_pct = 100, req_pct = 100;
  bit  db_req = 1'b0;
  int  db_val = 0;
  bit  coinc_arm = 1'b0;
  int  coinc_val = 0;
  bit  prev_hold = 1'b0;
  logic [511:0]     prev_data;
  logic [IDX_W-1:0] prev_slot;

  function automatic logic [63:0] pat(longint unsigned a, int b);
    return {a[31:0] + 32'(b), 32'hC0DE_0000 | 32'(b)};
  endfunction

  function automatic logic [511:0] cmd_exp(longint unsigned a);
    logic [511:0] w;
    for (int k = 0; k < 8; k++) w[k*64 +: 64] = pat(a, k);
    return w;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-cycle reference model and comparison
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "WATCHDOG", "run timeout", cycles, 150000);
      finish_run();
    end
    if (!rst_n) begin
      m_head = 0; m_tail = 0; m_err = 0; pend.delete(); beat_idx = 0;
      prev_hold = 0;
      db_wr = 0; rd_rsp_valid = 0; rd_req_ready = 0; cmd_ready = 0;
    end else begin
      chk(sq_head == IDX_W'(m_head), "R8", "sq_head", sq_head, m_head);
      chk(db_err == m_err, "R3", "db_err", db_err, m_err);
      if (rd_req_valid) begin
        chk(rd_req_addr == cfg_base + 64'(m_head) * 64, "R4", "rd_req_addr",
            rd_req_addr, cfg_base + 64'(m_head) * 64);
        chk(m_head != m_tail, "R2", "request with empty ring", m_head, m_tail);
      end
      if (rd_rsp_ready)
        chk(pend.size() != 0, "R5", "rd_rsp_ready without request", 1, 0);
      if (prev_hold) begin
        chk(cmd_valid && cmd_data == prev_data && cmd_slot == prev_slot,
            "R6", "held command changed", cmd_slot, prev_slot);
      end
      // drive inputs
      db_wr = db_req; db_tail = IDX_W'(db_val); db_req = 0;
      cmd_ready = ($urandom_range(99) < rdy_pct);
      rd_req_ready = ($urandom_range(99) < req_pct);
      if (coinc_arm && cmd_valid) begin
        db_wr = 1; db_tail = IDX_W'(coinc_val); cmd_ready = 1; coinc_arm = 0;
      end
      rd_rsp_valid = (pend.size() != 0) && ($urandom_range(99) < rsp_pct);
      rd_rsp_data  = (pend.size() != 0) ? pat(pend[0], beat_idx) : 64'h0;
      #1;
      // predict the coming edge
      prev_hold = cmd_valid && !cmd_ready;
      prev_data = cmd_data; prev_slot = cmd_slot;
      if (rd_req_valid && rd_req_ready) pend.push_back(rd_req_addr);
      if (rd_rsp_valid && rd_rsp_ready) begin
        beat_idx++;
        if (beat_idx == 8) begin beat_idx = 0; void'(pend.pop_front()); end
      end
      if (cmd_valid && cmd_ready) begin
        chk(cmd_slot == IDX_W'(m_head), "R6", "cmd_slot", cmd_slot, m_head);
        chk(cmd_qid == cfg_qid, "R6", "cmd_qid", cmd_qid, cfg_qid);
        chk(cmd_data == cmd_exp(cfg_base + 64'(m_head) * 64), "R5", "cmd_data beat order",
            cmd_data[63:0], cmd_exp(cfg_base + 64'(m_head) * 64) >> 0);
        cmd_count++;
        m_head = (m_head == int'(cfg_depth) - 1) ? 0 : m_head + 1;
      end
      m_err = db_wr && (int'(db_tail) >= int'(cfg_depth));
      if (db_wr && int'(db_tail) < int'(cfg_depth)) m_tail = int'(db_tail);
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic ring(int v);
    db_val = v; db_req = 1; tick();
  endtask

  task automatic drain();
    int n = 0;
    tick(); tick();
    while (!(m_head == m_tail && !cmd_valid && !rd_req_valid && pend.size() == 0 && !db_req)) begin
      tick(); n++;
      if (n > 5000) begin
        chk(1'b0, "R2", "drain timeout", m_head, m_tail);
        return;
      end
    end
    repeat (3) tick();
  endtask

  task automatic do_reset(logic [7:0] depth, logic [15:0] qid, logic [63:0] base);
    tick(); rst_n = 0; cfg_depth = depth; cfg_qid = qid; cfg_base = base;
    repeat (3) tick();
    chk(sq_head == 0 && !cmd_valid && !rd_req_valid && !rd_rsp_ready && !db_err,
        "R1", "state in reset", sq_head, 0);
    rst_n = 1;
    tick();
    chk(sq_head == 0 && !cmd_valid && !rd_req_valid && !db_err,
        "R1", "state after reset", sq_head, 0);
  endtask

  initial begin
    do_reset(8'd8, 16'd5, 64'h0000_0001_0000_0000);
    // R2: plain fetch
    ring(3); drain();
    chk(sq_head == 3, "R2", "head after tail 3", sq_head, 3);
    // R7: wrap
    ring(7); drain(); ring(2); drain();
    chk(sq_head == 2, "R7", "head after wrap", sq_head, 2);
    // R3: out-of-range doorbells
    ring(8); ring(200);
    repeat (10) begin
      tick();
      chk(!rd_req_valid, "R3", "fetch after bad doorbell", rd_req_valid, 0);
    end
    chk(sq_head == 2, "R3", "head after bad doorbell", sq_head, 2);
    // R6: back-pressure on both sides
    rdy_pct = 40; rsp_pct = 50; req_pct = 30;
    ring(6); drain(); ring(1); drain();
    chk(sq_head == 1, "R6", "head after back-pressure run", sq_head, 1);
    // R9: doorbell together with command handshake
    rdy_pct = 100; rsp_pct = 70; req_pct = 100;
    cmd_count = 0;
    coinc_val = 0; coinc_arm = 1;
    ring(4); drain();
    chk(sq_head == 0 && cmd_count == 7, "R9", "coincident doorbell", cmd_count, 7);
    // second configuration
    do_reset(8'd5, 16'd9, 64'h0000_0000_8000_0040);
    rdy_pct = 60; rsp_pct = 80;
    ring(4); drain(); ring(1); drain();
    chk(sq_head == 1, "R7", "head after depth-5 wrap", sq_head, 1);
    finish_run();
  end
endmodule